// File: doc/BRIEF.md
# Duplex Resolution and Collision-Test Control

This block sits beside the basic control register of an Ethernet PHY. It decides the duplex mode the link runs in and drives the collision output during a collision self-test. A hardware/software strap selects the source of the duplex mode. With the strap low, a board pin sets the mode. With the strap high, the mode comes from the auto-negotiation result while negotiation is enabled, and from a register bit otherwise. While loopback is active and negotiation is off, the resolved mode is frozen at its last value. The resolved mode is a registered status output.

The collision-test bit makes the collision output track transmit enable, with delays counted in bit-time ticks. The output rises after `ASSERT_TICKS` ticks of continuous transmit enable, well inside the 512 bit-time bound. It falls `DEASSERT_TICKS` ticks after transmit enable drops, inside the 4 bit-time bound. This works whether or not loopback is active. Software reaches the two control bits through a plain 9-bit write/read port. Bit 8 is the duplex bit (1 = full), bit 7 is the collision-test enable, and bits 6:0 are reserved.

Top module: `pdx_ctl`

## Requirements
- R1: With `strap_sw` low, `duplex_full` equals the value `dpx_pin` had at the previous clock edge, whatever register bit 8 holds.
- R2: With `strap_sw` high and `an_en` high, `duplex_full` equals the previous-edge value of `an_full`, whatever register bit 8 holds.
- R3: With `strap_sw` high and both `an_en` and `lpbk` low, register bit 8 selects the mode (0 half, 1 full). It takes effect on the second clock edge after the write.
- R4: With `strap_sw` high, `an_en` low and `lpbk` high, `duplex_full` holds its last value, and writes to register bit 8 do not change it.
- R5: A synchronous reset (`rst` high at a clock edge) clears `reg_rdata`, `col` and `duplex_full` to 0.
- R6: While register bit 7 (collision test) is 0, `col` stays 0 whatever `tx_en` does.
- R7: With bit 7 set, `col` rises at the clock edge of the `ASSERT_TICKS`-th (default 8) `bit_tick` seen while `tx_en` has been held high. This holds with `lpbk` high as well.
- R8: With `col` high, `col` falls at the clock edge of the `DEASSERT_TICKS`-th (default 2) `bit_tick` seen while `tx_en` has been held low.
- R9: A `tx_en` pulse that spans fewer than `ASSERT_TICKS` ticks produces no `col` pulse.
- R10: `reg_rdata` bits 6:0 always read 0. Writes to them are discarded, and bits 8:7 read back as written, one edge after `reg_wr`.
- R11: Clearing bit 7 while `col` is high drives `col` low by the second clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe for the control slice |
| reg_wdata | input | 9 | Write data: bit 8 duplex, bit 7 collision test, 6:0 reserved |
| reg_rdata | output | 9 | Read-back of the control slice |
| strap_sw | input | 1 | Strap: 0 pin-controlled, 1 software-controlled |
| dpx_pin | input | 1 | Duplex select pin, 1 = full |
| an_en | input | 1 | Auto-negotiation enable |
| an_full | input | 1 | Auto-negotiation result, 1 = full |
| lpbk | input | 1 | Loopback active |
| tx_en | input | 1 | Transmit enable |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| col | output | 1 | Collision output |
| duplex_full | output | 1 | Resolved duplex status, 1 = full |

## Verification
Duplex resolution is driven through every strap/negotiation/loopback combination. In each case the unselected sources are set to the opposite value, so a wrong priority shows up on `duplex_full`. The collision path gets one long pulse counted tick by tick, then a pulse one tick short of the threshold, then a long pulse under loopback, and finally disable while asserted. Together these separate an off-by-one counter, a counter that fails to restart, and an enable that is ignored.

// File: rtl/pdx_pkg.sv
package pdx_pkg;
  localparam int REG_W  = 9;
  localparam int DUP_POS = 8;
  localparam int CT_POS  = 7;
  localparam int RSV_W   = 7;

  typedef struct packed {
    logic dup_full;
    logic col_test;
  } ctl_bits_t;
endpackage

// File: rtl/pdx_ctl_reg.sv
module pdx_ctl_reg
  import pdx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output ctl_bits_t        bits
);
  ctl_bits_t q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr) begin
      q.dup_full <= wdata[DUP_POS];
      q.col_test <= wdata[CT_POS];
    end
  end

  // reserved field is never stored
  assign rdata = {q.dup_full, q.col_test, {RSV_W{1'b0}}};
  assign bits  = q;
endmodule

// File: rtl/pdx_resolver.sv
module pdx_resolver (
  input  logic clk,
  input  logic rst,
  input  logic strap_sw,
  input  logic dpx_pin,
  input  logic an_en,
  input  logic an_full,
  input  logic lpbk,
  input  logic reg_dup,
  output logic duplex_full
);
  logic nxt;

  // priority: strap pin, then negotiation, then loopback hold, then register
  always_comb begin
    if (!strap_sw)   nxt = dpx_pin;
    else if (an_en)  nxt = an_full;
    else if (lpbk)   nxt = duplex_full;
    else             nxt = reg_dup;
  end

  always_ff @(posedge clk) begin
    if (rst) duplex_full <= 1'b0;
    else     duplex_full <= nxt;
  end
endmodule

// File: rtl/pdx_col_timer.sv
module pdx_col_timer #(
  parameter int ASSERT_TICKS   = 8,
  parameter int DEASSERT_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic tx_en,
  input  logic bit_tick,
  output logic col
);
  localparam int MAXT = (ASSERT_TICKS > DEASSERT_TICKS) ? ASSERT_TICKS : DEASSERT_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = col ? CW'(DEASSERT_TICKS - 1) : CW'(ASSERT_TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      col <= 1'b0;
      cnt <= '0;
    end else if (tx_en == col) begin
      cnt <= '0;                 // no pending change: restart the count
    end else if (bit_tick) begin
      if (cnt >= last) begin
        col <= ~col;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdx_ctl.sv
module pdx_ctl
  import pdx_pkg::*;
#(
  parameter int ASSERT_TICKS   = 8,
  parameter int DEASSERT_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             strap_sw,
  input  logic             dpx_pin,
  input  logic             an_en,
  input  logic             an_full,
  input  logic             lpbk,
  input  logic             tx_en,
  input  logic             bit_tick,
  output logic             col,
  output logic             duplex_full
);
  ctl_bits_t bits;

  pdx_ctl_reg u_reg (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .bits(bits)
  );

  pdx_resolver u_res (
    .clk(clk), .rst(rst), .strap_sw(strap_sw), .dpx_pin(dpx_pin),
    .an_en(an_en), .an_full(an_full), .lpbk(lpbk),
    .reg_dup(bits.dup_full), .duplex_full(duplex_full)
  );

  pdx_col_timer #(.ASSERT_TICKS(ASSERT_TICKS), .DEASSERT_TICKS(DEASSERT_TICKS)) u_col (
    .clk(clk), .rst(rst), .enable(bits.col_test), .tx_en(tx_en),
    .bit_tick(bit_tick), .col(col)
  );
endmodule

// File: rtl/pdx_ctl_chk.sv
module pdx_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic [8:0] reg_rdata,
  input logic       strap_sw,
  input logic       dpx_pin,
  input logic       an_en,
  input logic       an_full,
  input logic       lpbk,
  input logic       tx_en,
  input logic       bit_tick,
  input logic       col,
  input logic       duplex_full
);
  a_r1_pin_rules: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strap_sw)) |-> duplex_full == $past(dpx_pin));

  a_r2_an_rules: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strap_sw) && $past(an_en)) |-> duplex_full == $past(an_full));

  a_r4_lpbk_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strap_sw) && !$past(an_en) && $past(lpbk))
      |-> duplex_full == $past(duplex_full));

  a_r6_col_off: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(reg_rdata[7])) |-> !col);

  a_r7_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(col) |-> ($past(tx_en) && $past(bit_tick)));

  a_r8_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(col) |-> (!$past(tx_en) || !$past(reg_rdata[7])));

  a_r10_rsv_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[6:0] == 7'd0);
endmodule

bind pdx_ctl pdx_ctl_chk u_chk (
  .clk(clk), .rst(rst), .reg_rdata(reg_rdata), .strap_sw(strap_sw),
  .dpx_pin(dpx_pin), .an_en(an_en), .an_full(an_full), .lpbk(lpbk),
  .tx_en(tx_en), .bit_tick(bit_tick), .col(col), .duplex_full(duplex_full)
);

// File: tb/pdx_ctl_bench.sv
module pdx_ctl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [8:0] reg_wdata = '0;
  logic [8:0] reg_rdata;
  logic       strap_sw = 1'b0, dpx_pin = 1'b0, an_en = 1'b0, an_full = 1'b0, lpbk = 1'b0;
  logic       tx_en = 1'b0, bit_tick = 1'b0;
  logic       col, duplex_full;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    int         sig;   // 0 col, 1 duplex_full, 2 reg_rdata
    logic [8:0] exp;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  pdx_ctl u_pdx_ctl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .strap_sw(strap_sw), .dpx_pin(dpx_pin), .an_en(an_en), .an_full(an_full), .lpbk(lpbk),
    .tx_en(tx_en), .bit_tick(bit_tick), .col(col), .duplex_full(duplex_full)
  );

  // monitor: compares everything expected after the last edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [8:0] act;
      it = sb.pop_front();
      case (it.sig)
        0: act = {8'd0, col};
        1: act = {8'd0, duplex_full};
        default: act = reg_rdata;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s sig%0d actual=%h expected=%h at %0t", it.req, it.sig, act, it.exp, $time);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_v(input string req, input int sig, input logic [8:0] exp);
    item_t it;
    it.req = req; it.sig = sig; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic write_reg(input logic [8:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // one ticked edge followed by one idle edge; expect col after the ticked edge
  task automatic tick_and_expect(input string req, input logic exp_col);
    bit_tick = 1'b1;
    step();
    bit_tick = 1'b0;
    expect_v(req, 0, {8'd0, exp_col});
    step();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R5 reset state
    expect_v("R5", 2, 9'h000);
    expect_v("R5", 0, 9'h000);
    expect_v("R5", 1, 9'h000);
    step();

    // R10 reserved bits discarded, bits 8:7 stored
    write_reg(9'h1FF);
    expect_v("R10", 2, 9'h180);
    step();
    write_reg(9'h07F);
    expect_v("R10", 2, 9'h000);
    step();

    // R1 strap low: pin wins against register
    write_reg(9'h000);
    strap_sw = 1'b0; dpx_pin = 1'b1;
    step();
    expect_v("R1", 1, 9'h001);
    write_reg(9'h100);
    dpx_pin = 1'b0;
    step();
    expect_v("R1", 1, 9'h000);
    step();

    // R2 strap high, negotiation on: result wins against register (bit 8 = 1)
    strap_sw = 1'b1; an_en = 1'b1; an_full = 1'b0;
    step();
    expect_v("R2", 1, 9'h000);
    an_full = 1'b1;
    write_reg(9'h000);
    expect_v("R2", 1, 9'h001);
    step();

    // R3 register decides
    an_en = 1'b0; an_full = 1'b1; dpx_pin = 1'b1;
    step();
    expect_v("R3", 1, 9'h000);
    write_reg(9'h100);
    step();
    expect_v("R3", 1, 9'h001);
    step();

    // R4 loopback freezes the full-duplex value
    lpbk = 1'b1;
    write_reg(9'h000);
    step(); step();
    expect_v("R4", 1, 9'h001);
    step();
    lpbk = 1'b0;
    step();
    expect_v("R3", 1, 9'h000);
    step();

    // R6 collision test off: no col
    tx_en = 1'b1;
    for (int i = 0; i < 10; i++) tick_and_expect("R6", 1'b0);
    tx_en = 1'b0;
    step();

    // R7 / R8 long pulse
    write_reg(9'h080);
    expect_v("R10", 2, 9'h080);
    tx_en = 1'b1;
    for (int i = 0; i < 7; i++) tick_and_expect("R7", 1'b0);
    tick_and_expect("R7", 1'b1);
    tx_en = 1'b0;
    tick_and_expect("R8", 1'b1);
    tick_and_expect("R8", 1'b0);

    // R9 pulse one tick short
    tx_en = 1'b1;
    for (int i = 0; i < 7; i++) tick_and_expect("R9", 1'b0);
    tx_en = 1'b0;
    for (int i = 0; i < 10; i++) tick_and_expect("R9", 1'b0);

    // R7 under loopback
    lpbk = 1'b1;
    tx_en = 1'b1;
    for (int i = 0; i < 7; i++) tick_and_expect("R7_lpbk", 1'b0);
    tick_and_expect("R7_lpbk", 1'b1);

    // R11 disable while asserted
    write_reg(9'h000);
    step();
    expect_v("R11", 0, 9'h000);
    step();
    tx_en = 1'b0; lpbk = 1'b0;
    step(); step();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule